// File: doc/BRIEF.md
# NAND Asynchronous Bus Cycle Generator

This block lets a host processor drive a raw 8-bit asynchronous NAND flash one bus cycle at a time. The host talks to it over a simple register bus. Each request is held until it is acknowledged. Two registers at the bottom of the map set the chip-enable select, the write-protect pin and the strobe timing, and show the flash ready line.

Each of up to four chip selects has its own window in the map. A host write to a window's command, address or data port becomes exactly one flash write cycle, with CLE, ALE or neither raised. A host read of the data port becomes one RE# cycle, and the sampled byte is returned to the host.

Every bus cycle has three phases: chip enable before the strobe, the strobe pulse, and chip enable after the strobe. The length of each phase, in clock cycles, comes from the timing register. A host access that arrives while a bus cycle is running is stalled until that cycle ends.

Top module: `nand_cycle_gen`

## Requirements
- R1: After reset, every CE# output is high, WE# and RE# are high, CLE and ALE are low, DQ is not driven and WP# is low. The control register reads 0 in bits [8:0], and the timing register reads 0x1081.
- R2: The control register is at address 0x000. Bits [7:0] hold a chip-enable select that reads back as written. Bit 8 drives the WP# pin directly, and writing 1 releases write protection. A write to bit 9 has no effect.
- R3: The timing register is at address 0x004. It has a setup field in bits [17:12], a pulse field in bits [10:5] and a hold field in bits [4:0]. All other bits read as 0.
- R4: A write to the command port of bank b (address 0x808 + b×0x100) produces one WE# cycle. During that cycle CLE is high, ALE is low and DQ carries write data bits [7:0].
- R5: A write to the address port of bank b (address 0x804 + b×0x100) produces one WE# cycle. During that cycle ALE is high, CLE is low and DQ carries write data bits [7:0].
- R6: A write to the data port of bank b (address 0x800 + b×0x100) produces one WE# cycle. During that cycle CLE and ALE are low and DQ carries write data bits [7:0].
- R7: A read of the data port of bank b produces one RE# cycle, with DQ left undriven. The read returns, in bits [7:0] and with all upper bits 0, the byte present on DQ during the last clock cycle that RE# is low.
- R8: In every bus cycle, CE# is low with the strobe high for `setup` clock cycles. The strobe is then low for `pulse` cycles. CE# then stays low with the strobe high for `hold` cycles. A field value of 0 counts as 1.
- R9: During a bus cycle, only the CE# of the addressed bank is low. WE# and RE# are never low together. With all CE# high, both strobes are high and CLE and ALE are low. DQ is driven only in write cycles, and only while CE# is low.
- R10: An access is acknowledged only while no bus cycle runs. A port write is acknowledged in the cycle in which it is issued, and its bus cycle begins at the next edge. A data-port read is acknowledged one cycle after its bus cycle ends.
- R11: Several accesses are acknowledged without starting a bus cycle: offsets in a bank window other than 0x00, 0x04 and 0x08, reads of the address or command port, and addresses outside all defined ranges. Their reads return 0.
- R12: Control bit 9 reads the level of R/B# after a two-flop synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_req | input | 1 | Host access request, held until acknowledged |
| hst_wr | input | 1 | 1 = write, 0 = read |
| hst_addr | input | 12 | Byte address of the access |
| hst_wdata | input | 32 | Write data |
| hst_rdata | output | 32 | Read data, valid while hst_ack is high |
| hst_ack | output | 1 | Access completes in this cycle |
| ce_n | output | NUM_CS | Flash chip enables, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| dq_out | output | 8 | Data driven toward the flash |
| dq_oe | output | 1 | Output enable for dq_out |
| dq_in | input | 8 | Data sampled from the flash |
| rb_n | input | 1 | Flash ready/busy, low while busy |
| wp_n | output | 1 | Flash write protect, active low |

## Verification
The bench sends a random stream of command, address, data-write and data-read accesses to random banks, with a random byte each time. The stream is interleaved with random rewrites of the timing register whose fields include 0. For each access, the bench measures each phase's length, the latch lines, the CE# pattern and the driven byte. This separates a swapped CLE/ALE, a wrong bank decode, an off-by-one phase counter and a mishandled zero field. The bench's flash model puts the correct byte on DQ only in the final RE# cycle, so a read that samples one cycle early or late returns a wrong value. Directed cases cover a register access that is stalled behind a running cycle, unmapped window offsets, the synchronized ready bit and write-protect readback.

// File: rtl/nandcg_pkg.sv
package nandcg_pkg;
   localparam int ADDR_W  = 12;
   localparam int SETUP_W = 6;
   localparam int PULSE_W = 6;
   localparam int HOLD_W  = 5;
   localparam int CNT_W   = 6;

   typedef struct packed {
      logic [SETUP_W-1:0] setup;
      logic [PULSE_W-1:0] pulse;
      logic [HOLD_W-1:0]  hold;
   } nandcg_tim_t;

   typedef enum logic [1:0] {CYC_DOUT, CYC_ADDR, CYC_CMD, CYC_DIN} nandcg_kind_t;
   typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_PULSE, ST_HOLD} nandcg_state_t;

   // Count value that makes a phase last v cycles; 0 is read as 1.
   function automatic logic [CNT_W-1:0] last_cnt(input logic [CNT_W-1:0] v);
      return (v == '0) ? '0 : v - 1'b1;
   endfunction
endpackage

// File: rtl/nandcg_regs.sv
module nandcg_regs
   import nandcg_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_ctrl,
   input  logic        wr_tim,
   input  logic [31:0] wdata,
   input  logic        rb_n,
   output logic [7:0]  sel_q,
   output logic        wp_q,
   output logic        rdy,
   output nandcg_tim_t tim_q
);
   logic rb_meta_q, rb_sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
         wp_q  <= 1'b0;
      end else if (wr_ctrl) begin
         sel_q <= wdata[7:0];
         wp_q  <= wdata[8];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tim_q.setup <= SETUP_W'(1);
         tim_q.pulse <= PULSE_W'(4);
         tim_q.hold  <= HOLD_W'(1);
      end else if (wr_tim) begin
         tim_q.setup <= wdata[17:12];
         tim_q.pulse <= wdata[10:5];
         tim_q.hold  <= wdata[4:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rb_meta_q <= 1'b0;
         rb_sync_q <= 1'b0;
      end else begin
         rb_meta_q <= rb_n;
         rb_sync_q <= rb_meta_q;
      end
   end

   assign rdy = rb_sync_q;

   // R12
   rdy_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rb_meta_q) == rdy);
endmodule

// File: rtl/nandcg_engine.sv
module nandcg_engine
   import nandcg_pkg::*;
#(
   parameter int NUM_CS = 4,
   parameter int CS_W   = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  nandcg_kind_t      kind,
   input  logic [CS_W-1:0]   bank,
   input  logic [7:0]        wbyte,
   input  nandcg_tim_t       tim,
   input  logic [7:0]        dq_in,
   output logic              busy,
   output logic              rd_fin,
   output logic [7:0]        rd_byte,
   output logic [NUM_CS-1:0] ce_n,
   output logic              cle,
   output logic              ale,
   output logic              we_n,
   output logic              re_n,
   output logic [7:0]        dq_out,
   output logic              dq_oe
);
   nandcg_state_t    state_q;
   logic [CNT_W-1:0] cnt_q;
   nandcg_kind_t     kind_q;
   logic [CS_W-1:0]  bank_q;
   logic [7:0]       byte_q;
   logic             rd_fin_q;
   logic             active, in_pulse, is_read;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         cnt_q    <= '0;
         kind_q   <= CYC_DOUT;
         bank_q   <= '0;
         byte_q   <= '0;
         rd_fin_q <= 1'b0;
      end else begin
         rd_fin_q <= 1'b0;
         case (state_q)
            ST_IDLE: if (start) begin
               state_q <= ST_SETUP;
               cnt_q   <= last_cnt(tim.setup);
               kind_q  <= kind;
               bank_q  <= bank;
               byte_q  <= wbyte;
            end
            ST_SETUP: if (cnt_q == '0) begin
               state_q <= ST_PULSE;
               cnt_q   <= last_cnt(tim.pulse);
            end else cnt_q <= cnt_q - 1'b1;
            ST_PULSE: if (cnt_q == '0) begin
               state_q <= ST_HOLD;
               cnt_q   <= last_cnt({1'b0, tim.hold});
               if (kind_q == CYC_DIN) byte_q <= dq_in;
            end else cnt_q <= cnt_q - 1'b1;
            default: if (cnt_q == '0) begin
               state_q  <= ST_IDLE;
               rd_fin_q <= (kind_q == CYC_DIN);
            end else cnt_q <= cnt_q - 1'b1;
         endcase
      end
   end

   assign active   = (state_q != ST_IDLE);
   assign in_pulse = (state_q == ST_PULSE);
   assign is_read  = (kind_q == CYC_DIN);

   for (genvar i = 0; i < NUM_CS; i++) begin : g_ce
      assign ce_n[i] = !(active && (bank_q == CS_W'(i)));
   end

   assign cle     = active && (kind_q == CYC_CMD);
   assign ale     = active && (kind_q == CYC_ADDR);
   assign we_n    = !(in_pulse && !is_read);
   assign re_n    = !(in_pulse && is_read);
   assign dq_oe   = active && !is_read;
   assign dq_out  = byte_q;
   assign busy    = active;
   assign rd_fin  = rd_fin_q;
   assign rd_byte = byte_q;

   // R9
   dq_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> (ce_n != {NUM_CS{1'b1}}));
   // R9
   one_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!we_n || !re_n) |-> ($countones(~ce_n) == 1));
   // R9
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!we_n && !re_n));
   // R4
   latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cle && ale));
   // R7
   rd_fin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_fin |-> $past(ce_n != {NUM_CS{1'b1}}));
   // R10
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);
endmodule

// File: rtl/nand_cycle_gen.sv
module nand_cycle_gen
   import nandcg_pkg::*;
#(
   parameter int NUM_CS = 4,
   parameter int DATA_W = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hst_req,
   input  logic              hst_wr,
   input  logic [11:0]       hst_addr,
   input  logic [DATA_W-1:0] hst_wdata,
   output logic [DATA_W-1:0] hst_rdata,
   output logic              hst_ack,
   output logic [NUM_CS-1:0] ce_n,
   output logic              cle,
   output logic              ale,
   output logic              we_n,
   output logic              re_n,
   output logic [7:0]        dq_out,
   output logic              dq_oe,
   input  logic [7:0]        dq_in,
   input  logic              rb_n,
   output logic              wp_n
);
   localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

   if (NUM_CS < 1 || NUM_CS > 4) begin : g_bad_cs
      $error("nand_cycle_gen: NUM_CS must be 1 to 4");
   end
   if (DATA_W != 32) begin : g_bad_dw
      $error("nand_cycle_gen: DATA_W must be 32");
   end

   logic [7:0]      sel_q, off, rd_byte;
   logic [2:0]      win;
   logic [CS_W-1:0] bank;
   logic            wp_q, rdy, busy, rd_fin, start;
   logic            is_ctrl, is_tim, is_bank, p_dat, p_adr, p_cmd;
   logic            bank_rd, bank_cyc;
   nandcg_tim_t     tim_q;
   nandcg_kind_t    kind;
   logic            unused_wdata;

   assign unused_wdata = ^{hst_wdata[DATA_W-1:18], hst_wdata[11]};

   assign off     = hst_addr[7:0];
   assign win     = hst_addr[10:8];
   assign bank    = win[CS_W-1:0];
   assign is_ctrl = (hst_addr == 12'h000);
   assign is_tim  = (hst_addr == 12'h004);
   assign is_bank = hst_addr[11] && (win < 3'(NUM_CS));
   assign p_dat   = is_bank && (off == 8'h00);
   assign p_adr   = is_bank && (off == 8'h04);
   assign p_cmd   = is_bank && (off == 8'h08);
   assign bank_rd = p_dat && !hst_wr;
   assign bank_cyc = p_dat || ((p_adr || p_cmd) && hst_wr);

   always_comb begin
      if (p_cmd)       kind = CYC_CMD;
      else if (p_adr)  kind = CYC_ADDR;
      else if (hst_wr) kind = CYC_DOUT;
      else             kind = CYC_DIN;
   end

   assign start   = hst_req && !busy && bank_cyc && !rd_fin;
   assign hst_ack = hst_req && !busy && (bank_rd ? rd_fin : !rd_fin);

   always_comb begin
      hst_rdata = '0;
      if (is_ctrl)      hst_rdata[9:0]  = {rdy, wp_q, sel_q};
      else if (is_tim)  hst_rdata[17:0] = {tim_q.setup, 1'b0, tim_q.pulse, tim_q.hold};
      else if (bank_rd) hst_rdata[7:0]  = rd_byte;
   end

   nandcg_regs u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ctrl (hst_ack && hst_wr && is_ctrl),
      .wr_tim  (hst_ack && hst_wr && is_tim),
      .wdata   (hst_wdata[31:0]),
      .rb_n    (rb_n),
      .sel_q   (sel_q),
      .wp_q    (wp_q),
      .rdy     (rdy),
      .tim_q   (tim_q)
   );

   nandcg_engine #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_engine (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .kind    (kind),
      .bank    (bank),
      .wbyte   (hst_wdata[7:0]),
      .tim     (tim_q),
      .dq_in   (dq_in),
      .busy    (busy),
      .rd_fin  (rd_fin),
      .rd_byte (rd_byte),
      .ce_n    (ce_n),
      .cle     (cle),
      .ale     (ale),
      .we_n    (we_n),
      .re_n    (re_n),
      .dq_out  (dq_out),
      .dq_oe   (dq_oe)
   );

   assign wp_n = wp_q;

   // R10
   stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hst_req && busy) |-> !hst_ack);
   // R2
   wp_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hst_ack && hst_wr && is_ctrl) |=> (wp_n == $past(hst_wdata[8])));
endmodule

// File: tb/nand_cycle_gen_tb_top.sv
module nand_cycle_gen_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hst_req = 1'b0, hst_wr = 1'b0;
   logic [11:0] hst_addr = '0;
   logic [31:0] hst_wdata = '0;
   logic [31:0] hst_rdata;
   logic        hst_ack;
   logic [3:0]  ce_n;
   logic        cle, ale, we_n, re_n, dq_oe, wp_n;
   logic [7:0]  dq_out;
   logic [7:0]  dq_in = 8'h00;
   logic        rb_n = 1'b1;

   always #10 clk = ~clk;

   nand_cycle_gen dut_i (
      .clk(clk), .rst_n(rst_n), .hst_req(hst_req), .hst_wr(hst_wr),
      .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
      .hst_ack(hst_ack), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
      .re_n(re_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in),
      .rb_n(rb_n), .wp_n(wp_n)
   );

   int checks = 0, errors = 0;
   bit done_f = 0;
   int cur_s = 1, cur_p = 4, cur_h = 1;
   logic [7:0] rd_val = 8'h00;

   // bus monitor state
   bit m_in = 0, m_bad = 0, idle_bad = 0, m_cle, m_ale, m_we, m_re, m_oe_all, m_oe_any;
   logic [3:0] m_ce = 4'hF;
   logic [7:0] m_dq;
   int m_s, m_p, m_h, m_n = 0;

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", rq, act, exp);
      end
   endtask

   function automatic int eff(input int v);
      return (v == 0) ? 1 : v;
   endfunction

   always @(negedge clk) begin
      if (rst_n) begin
         dq_in <= ~rd_val;
         if (ce_n != 4'hF) begin
            if (!m_in) begin
               m_in = 1; m_ce = ce_n; m_s = 0; m_p = 0; m_h = 0;
               m_cle = 0; m_ale = 0; m_we = 0; m_re = 0;
               m_oe_all = 1; m_oe_any = 0; m_dq = 8'h00;
            end
            if (ce_n != m_ce || $countones(~ce_n) != 1) m_bad = 1;
            if (dq_oe) m_oe_any = 1; else m_oe_all = 0;
            if (!we_n || !re_n) begin
               if (!we_n && !re_n) m_bad = 1;
               if (m_h != 0) m_bad = 1;
               m_p++;
               m_cle = cle; m_ale = ale;
               if (!we_n) begin m_we = 1; m_dq = dq_out; end
               if (!re_n) m_re = 1;
               if (!re_n && m_p == cur_p) dq_in <= rd_val;
            end else if (m_p == 0) m_s++;
            else m_h++;
         end else begin
            if (m_in) begin m_in = 0; m_n++; end
            if (!we_n || !re_n || dq_oe || cle || ale) idle_bad = 1;
         end
      end
   end

   task automatic host(input bit wr, input logic [11:0] a, input logic [31:0] d,
                       output logic [31:0] rd, output int waits);
      @(negedge clk);
      hst_req = 1; hst_wr = wr; hst_addr = a; hst_wdata = d;
      waits = 0;
      #1;
      while (!hst_ack && waits < 1000) begin
         @(negedge clk); #1; waits++;
      end
      rd = hst_rdata;
      @(posedge clk); #1;
      hst_req = 0;
   endtask

   task automatic set_tim(input int s, input int p, input int h);
      logic [31:0] r; int w;
      host(1, 12'h004, {14'h0, 6'(s), 1'b0, 6'(p), 5'(h)}, r, w);
      cur_s = eff(s); cur_p = eff(p); cur_h = eff(h);
   endtask

   // kind: 0 data write, 1 address, 2 command, 3 data read
   task automatic bank_op(input int kind, input int bank, input logic [7:0] b);
      logic [31:0] r; int w, n0, tot;
      logic [11:0] a;
      string rq;
      bit rd;
      n0 = m_n;
      rd = (kind == 3);
      a = 12'h800 | 12'(bank << 8) | ((kind == 1) ? 12'h004 : (kind == 2) ? 12'h008 : 12'h000);
      rq = (kind == 0) ? "R6" : (kind == 1) ? "R5" : (kind == 2) ? "R4" : "R7";
      if (rd) rd_val = b;
      tot = cur_s + cur_p + cur_h;
      host(!rd, a, {24'h0, b}, r, w);
      repeat (tot + 4) @(negedge clk);
      chk(m_n == n0 + 1, rq, m_n - n0, 1);
      chk(m_ce == ~(4'b1 << bank), "R9", m_ce, ~(4'b1 << bank) & 4'hF);
      chk(m_s == cur_s && m_p == cur_p && m_h == cur_h, "R8",
          m_s * 256 + m_p * 16 + m_h, cur_s * 256 + cur_p * 16 + cur_h);
      chk(m_cle == (kind == 2) && m_ale == (kind == 1), rq, {m_cle, m_ale},
          {kind == 2, kind == 1});
      chk(!m_bad && !idle_bad, "R9", {m_bad, idle_bad}, 0);
      if (rd) begin
         chk(m_re && !m_we && !m_oe_any, "R7", {m_re, m_we, m_oe_any}, 3'b100);
         chk(r == {24'h0, b}, "R7", r, b);
         chk(w == tot + 1, "R10", w, tot + 1);
      end else begin
         chk(m_we && !m_re && m_dq == b, rq, m_dq, b);
         chk(m_oe_all, "R9", m_oe_all, 1);
         chk(w == 0, "R10", w, 0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done_f) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      int w, n0;
      void'($urandom(32'h1ACE));
      repeat (5) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(ce_n == 4'hF && we_n && re_n && !cle && !ale && !dq_oe && !wp_n, "R1",
          {ce_n, we_n, re_n, cle, ale, dq_oe, wp_n}, 10'h3F0);
      host(0, 12'h004, 0, r, w);
      chk(r == 32'h1081, "R1", r, 32'h1081);
      host(0, 12'h000, 0, r, w);
      chk(r[8:0] == 0, "R1", r[8:0], 0);
      // R8 default timing 1/4/1
      bank_op(2, 0, 8'h70);
      // R2 control register
      host(1, 12'h000, 32'h0000_0304, r, w);
      @(negedge clk);
      chk(wp_n == 1'b1, "R2", wp_n, 1);
      host(0, 12'h000, 0, r, w);
      chk(r[8:0] == 9'h104, "R2", r[8:0], 9'h104);
      host(1, 12'h000, 32'h0, r, w);
      @(negedge clk);
      chk(wp_n == 1'b0, "R2", wp_n, 0);
      // R12 ready synchronizer
      rb_n = 0; repeat (4) @(negedge clk);
      host(0, 12'h000, 0, r, w);
      chk(r[9] == 1'b0, "R12", r[9], 0);
      rb_n = 1; repeat (4) @(negedge clk);
      host(0, 12'h000, 0, r, w);
      chk(r[9] == 1'b1, "R12", r[9], 1);
      // R3 field layout
      host(1, 12'h004, 32'hFFFF_FFFF, r, w);
      host(0, 12'h004, 0, r, w);
      chk(r == 32'h0003_F7FF, "R3", r, 32'h0003_F7FF);
      // R8 zero fields count as 1
      set_tim(0, 0, 0);
      bank_op(0, 3, 8'hA5);
      bank_op(3, 2, 8'h3C);
      set_tim(3, 1, 5);
      bank_op(3, 1, 8'hC3);
      // R10 register access stalled behind a running cycle
      bank_op(1, 1, 8'h11);
      host(1, 12'h808, 32'h90, r, w);
      host(0, 12'h000, 0, r, w);
      chk(w == cur_s + cur_p + cur_h, "R10", w, cur_s + cur_p + cur_h);
      repeat (20) @(negedge clk);
      // R11 unmapped offsets and non-cycle reads
      n0 = m_n;
      host(1, 12'h80C, 32'h55, r, w);
      host(0, 12'h904, 0, r, w);
      chk(r == 0, "R11", r, 0);
      host(0, 12'hA08, 0, r, w);
      chk(r == 0, "R11", r, 0);
      host(1, 12'h010, 32'h77, r, w);
      repeat (20) @(negedge clk);
      chk(m_n == n0 && !idle_bad, "R11", m_n - n0, 0);
      // random stream
      for (int i = 0; i < 40; i++) begin
         if (i % 5 == 0)
            set_tim($urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7));
         bank_op($urandom_range(0, 3), $urandom_range(0, 3), 8'($urandom_range(0, 255)));
      end
      done_f = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule